// File: doc/BRIEF.md
# Three-Stage Decomposed Sequence Controller

This block is an eight-state sequence controller whose combinational logic is cut into three cascaded stages instead of one flat next-state/output table. An input-selection stage looks at the present state and routes at most two of the eight condition inputs onto a narrow auxiliary bus. One condition input skips that stage and feeds the core directly. A core stage uses the auxiliary bus, the bypassed input and the present state to pick the next state and the output pattern of the transition taken. Seven outputs that occur in only one pattern are driven by the core as they are. The other seven outputs are packed into a 3-bit code, and a separate decoding stage expands that code.

The state, the directly driven outputs and the output code are registered together on the clock edge that takes the transition. The outputs after an edge therefore show the pattern of the transition just taken. The auxiliary bus, the registered output code and the state code are brought out so that each stage can be observed on its own.

Top module: `split_fsm_ctl`

## Requirements
- R1: While `rst_n` is low, `state_code` is 000, `y_out` is all zero and `q_code` is 000, with no clock edge needed. Input bit k-1 of `x_in` is condition xk, and output bit k-1 of `y_out` is output yk.
- R2: The states are encoded on `state_code` as S1=110, S2=000, S3=101, S4=010, S5=011, S6=100, S7=111 and S8=001. Reset enters S2.
- R3: `p_aux[0]` (p1) and `p_aux[1]` (p2) are selected from the present state as follows:
  - S1: p1=x1 and p2=x2.
  - S3: p1=x7 and p2=x8.
  - S5: p1=x4 and p2=x6.
  - S7: p1=x7 and p2=0.
  - S8: p1=0 and p2=x5.
  - Every other state: both bits 0.
- R4: In S4 the decision uses x3 directly and never the auxiliary bus. x3 high goes to S7, and x3 low goes to S8.
- R5: On each clock edge the state moves as follows:
  - S1 goes to S2 if p1 and otherwise holds.
  - S2 goes to S3.
  - S3 goes to S4 if p1&p2, to S5 if p1&!p2, and otherwise to S6.
  - S5 goes to S6 if p2, and otherwise to S1.
  - S6 goes to S7.
  - S7 goes to S8 if p1, and otherwise holds.
  - S8 goes to S1 if p2, and otherwise holds.
- R6: After each edge, `y_out` equals the output pattern of the transition taken:
  - S1→S2: {y2,y5,y10}
  - S2→S3: {y3,y4}
  - S3→S4: {y1,y3,y4}
  - S3→S5: {y10,y11}
  - S3→S6: {y6,y8}
  - S4→S7: {y1,y3}
  - S4→S8: {y9,y14}
  - S5→S6: {y7}
  - S5→S1: {y6,y13}
  - S6→S7: {y12}
  - S7→S8: {y3,y4}
  - S8→S1: {y10,y11}
  - Every hold: empty.
- R7: Outputs y2, y5, y7, y8, y9, y12 and y14 are driven directly from core registers. Because y2 belongs to one pattern only, y2 high always comes with y5 and y10 high.
- R8: `q_code` carries the reduced pattern of the encoded outputs: 0 is none, 1 is {y10}, 2 is {y3,y4}, 3 is {y1,y3,y4}, 4 is {y10,y11}, 5 is {y6}, 6 is {y1,y3} and 7 is {y6,y13}. Outputs y1, y3, y4, y6, y10, y11 and y13 follow the decoding of `q_code`.
- R9: `q_code` 000 drives none of the encoded outputs. A hold in S1, S7 or S8 leaves every output low.
- R10: In S2, S4 and S6 `p_aux` is 00 whatever `x_in` holds. S2 and S6 each advance unconditionally to the next state, S3 and S7 respectively, for any input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, to be released synchronously to clk |
| x_in | input | 8 | Condition inputs, bit k-1 is xk |
| y_out | output | 14 | Controller outputs, bit k-1 is yk |
| state_code | output | 3 | Present state code |
| p_aux | output | 2 | Auxiliary bus from the selection stage, {p2,p1} |
| q_code | output | 3 | Registered output code fed to the decoding stage |

## Verification
The bench builds the block with its package defaults: eight condition inputs, fourteen outputs, a 3-bit state and a 3-bit output code. With these values every one of the eight states, all fifteen transitions and all eight code values can be reached within a few dozen cycles. A directed walk therefore touches each transition, including the S4 branch on the bypassed input and the three holding states. A long pseudo-random input run then compares the state, the full output vector and the code against a flat transition table written from the original inputs. The auxiliary bus is checked against the selection rule in every cycle, and a reset asserted in the middle of a cycle confirms the asynchronous idle state.

// File: rtl/split_fsm_pkg.sv
`timescale 1ns/1ps
package split_fsm_pkg;

  // Widths and counts
  localparam int IN_W    = 8;            // condition inputs
  localparam int OUT_W   = 14;           // controller outputs
  localparam int ST_W    = 3;            // state register width
  localparam int AUX_W   = 2;            // selected auxiliary bits
  localparam int CODE_W  = 3;            // output code width
  localparam int CODE_N  = 1 << CODE_W;  // number of code values
  localparam int BYP_IDX = 2;            // x3 goes straight to the core

  // Input indices (bit k-1 holds xk)
  localparam int XI1 = 0;
  localparam int XI2 = 1;
  localparam int XI4 = 3;
  localparam int XI5 = 4;
  localparam int XI6 = 5;
  localparam int XI7 = 6;
  localparam int XI8 = 7;

  // Directly driven output indices (bit k-1 holds yk)
  localparam int YD2  = 1;
  localparam int YD5  = 4;
  localparam int YD7  = 6;
  localparam int YD8  = 7;
  localparam int YD9  = 8;
  localparam int YD12 = 11;
  localparam int YD14 = 13;

  // State codes; the selection logic depends on these bit patterns
  typedef enum logic [ST_W-1:0] {
    ST_S2 = 3'b000,
    ST_S8 = 3'b001,
    ST_S4 = 3'b010,
    ST_S5 = 3'b011,
    ST_S6 = 3'b100,
    ST_S3 = 3'b101,
    ST_S1 = 3'b110,
    ST_S7 = 3'b111
  } st_e;

  // Output pattern of a transition
  typedef enum logic [3:0] {
    PAT_0, PAT_1, PAT_2, PAT_3, PAT_4, PAT_5,
    PAT_6, PAT_7, PAT_8, PAT_9, PAT_10
  } pat_e;

  // Set of code values for which an encoded output is active
  function automatic logic [CODE_N-1:0] enc_members(input int idx);
    logic [CODE_N-1:0] m;
    case (idx)
      0:       m = 8'b0100_1000; // y1 : codes 3,6
      2:       m = 8'b0100_1100; // y3 : codes 2,3,6
      3:       m = 8'b0000_1100; // y4 : codes 2,3
      5:       m = 8'b1010_0000; // y6 : codes 5,7
      9:       m = 8'b0001_0010; // y10: codes 1,4
      10:      m = 8'b0001_0000; // y11: code 4
      12:      m = 8'b1000_0000; // y13: code 7
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/split_fsm_insel.sv
`timescale 1ns/1ps
module split_fsm_insel
  import split_fsm_pkg::*;
(
  input  st_e              state,
  input  logic [IN_W-1:0]  x,
  output logic [AUX_W-1:0] p,
  output logic             x_byp
);

  // One-hot decode of the present state
  logic in_s1, in_s3, in_s5, in_s7, in_s8;

  always_comb begin
    in_s1 = (state == ST_S1);
    in_s3 = (state == ST_S3);
    in_s5 = (state == ST_S5);
    in_s7 = (state == ST_S7);
    in_s8 = (state == ST_S8);
  end

  // Sum of state-gated products, one per routed input
  always_comb begin
    p[0] = (in_s1 & x[XI1]) |
           (in_s3 & x[XI7]) |
           (in_s5 & x[XI4]) |
           (in_s7 & x[XI7]);
    p[1] = (in_s1 & x[XI2]) |
           (in_s3 & x[XI8]) |
           (in_s5 & x[XI6]) |
           (in_s8 & x[XI5]);
  end

  assign x_byp = x[BYP_IDX];

endmodule

// File: rtl/split_fsm_core.sv
`timescale 1ns/1ps
module split_fsm_core
  import split_fsm_pkg::*;
(
  input  st_e               state,
  input  logic [AUX_W-1:0]  p,
  input  logic              x_byp,
  output st_e               state_nxt,
  output logic [OUT_W-1:0]  dir_out,
  output logic [CODE_W-1:0] code_out
);

  pat_e pat;
  logic p1, p2;

  assign p1 = p[0];
  assign p2 = p[1];

  // Next state and pattern of the transition taken
  always_comb begin
    state_nxt = state;
    pat       = PAT_0;
    unique case (state)
      ST_S1: if (p1) begin state_nxt = ST_S2; pat = PAT_1; end
      ST_S2: begin state_nxt = ST_S3; pat = PAT_2; end
      ST_S3: begin
        if (p1 && p2)       begin state_nxt = ST_S4; pat = PAT_3; end
        else if (p1 && !p2) begin state_nxt = ST_S5; pat = PAT_4; end
        else                begin state_nxt = ST_S6; pat = PAT_5; end
      end
      ST_S4: begin
        if (x_byp) begin state_nxt = ST_S7; pat = PAT_6; end
        else       begin state_nxt = ST_S8; pat = PAT_7; end
      end
      ST_S5: begin
        if (p2) begin state_nxt = ST_S6; pat = PAT_8; end
        else    begin state_nxt = ST_S1; pat = PAT_9; end
      end
      ST_S6: begin state_nxt = ST_S7; pat = PAT_10; end
      ST_S7: if (p1) begin state_nxt = ST_S8; pat = PAT_2; end
      ST_S8: if (p2) begin state_nxt = ST_S1; pat = PAT_4; end
    endcase
  end

  // Outputs owned by a single pattern are driven directly
  always_comb begin
    dir_out = '0;
    unique case (pat)
      PAT_1:   begin dir_out[YD2] = 1'b1; dir_out[YD5] = 1'b1; end
      PAT_5:   dir_out[YD8] = 1'b1;
      PAT_7:   begin dir_out[YD9] = 1'b1; dir_out[YD14] = 1'b1; end
      PAT_8:   dir_out[YD7] = 1'b1;
      PAT_10:  dir_out[YD12] = 1'b1;
      default: dir_out = '0;
    endcase
  end

  // Shared outputs are packed into a short code
  always_comb begin
    unique case (pat)
      PAT_1:   code_out = 3'd1;
      PAT_2:   code_out = 3'd2;
      PAT_3:   code_out = 3'd3;
      PAT_4:   code_out = 3'd4;
      PAT_5:   code_out = 3'd5;
      PAT_6:   code_out = 3'd6;
      PAT_9:   code_out = 3'd7;
      default: code_out = 3'd0;
    endcase
  end

endmodule

// File: rtl/split_fsm_outdec.sv
`timescale 1ns/1ps
module split_fsm_outdec
  import split_fsm_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  y_enc
);

  // Each output bit looks up its own membership set
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    localparam logic [CODE_N-1:0] MEMB = enc_members(i);
    assign y_enc[i] = MEMB[code];
  end

endmodule

// File: rtl/split_fsm_ctl.sv
`timescale 1ns/1ps
module split_fsm_ctl
  import split_fsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   x_in,
  output logic [OUT_W-1:0]  y_out,
  output logic [ST_W-1:0]   state_code,
  output logic [AUX_W-1:0]  p_aux,
  output logic [CODE_W-1:0] q_code
);

  st_e               state_q, state_d;
  logic [OUT_W-1:0]  dir_q, dir_d, dec_y;
  logic [CODE_W-1:0] code_q, code_d;
  logic [AUX_W-1:0]  p_sel;
  logic              x_byp;

  split_fsm_insel u_insel (
    .state (state_q),
    .x     (x_in),
    .p     (p_sel),
    .x_byp (x_byp)
  );

  split_fsm_core u_core (
    .state     (state_q),
    .p         (p_sel),
    .x_byp     (x_byp),
    .state_nxt (state_d),
    .dir_out   (dir_d),
    .code_out  (code_d)
  );

  // State, direct outputs and code move together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_S2;
      dir_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      code_q  <= code_d;
    end
  end

  split_fsm_outdec u_outdec (
    .code  (code_q),
    .y_enc (dec_y)
  );

  assign y_out      = dir_q | dec_y;
  assign state_code = state_q;
  assign p_aux      = p_sel;
  assign q_code     = code_q;

endmodule

// File: rtl/split_fsm_chk.sv
`timescale 1ns/1ps
module split_fsm_chk
  import split_fsm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ST_W-1:0]   state_code,
  input logic [AUX_W-1:0]  p_aux,
  input logic [CODE_W-1:0] q_code,
  input logic [OUT_W-1:0]  y_out
);

  localparam logic [OUT_W-1:0] ENC_MASK = 14'b01_0110_0010_1101;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (state_code == 3'b000 && y_out == '0 && q_code == '0));

  // R10
  pass_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_S2) |=> (state_code == ST_S3));

  // R10
  pass_s6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_S6) |=> (state_code == ST_S7));

  // R3
  aux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_S2 || state_code == ST_S4 || state_code == ST_S6)
      |-> (p_aux == '0));

  // R9
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_code == '0) |-> ((y_out & ENC_MASK) == '0));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_S1 && !p_aux[0]) |=> (state_code == ST_S1 && y_out == '0));

  // R7
  y2_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_out[YD2] |-> (y_out[YD5] && y_out[9]));

endmodule

bind split_fsm_ctl split_fsm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_code (state_code),
  .p_aux      (p_aux),
  .q_code     (q_code),
  .y_out      (y_out)
);

// File: tb/split_fsm_ctl_tb.sv
`timescale 1ns/1ps
module split_fsm_ctl_tb;

  localparam logic [2:0] A1 = 3'b110, A2 = 3'b000, A3 = 3'b101, A4 = 3'b010,
                         A5 = 3'b011, A6 = 3'b100, A7 = 3'b111, A8 = 3'b001;
  localparam logic [7:0] X1 = 8'h01, X2 = 8'h02, X3 = 8'h04, X4 = 8'h08,
                         X5 = 8'h10, X6 = 8'h20, X7 = 8'h40, X8 = 8'h80;

  typedef struct packed {
    logic [2:0]  st;
    logic [13:0] y;
    logic [2:0]  q;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  x_in = '0;
  logic [13:0] y_out;
  logic [2:0]  state_code;
  logic [1:0]  p_aux;
  logic [2:0]  q_code;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  logic [2:0] rs = A2;
  exp_t sb[$];

  always #5 clk = ~clk;

  split_fsm_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_out(y_out),
    .state_code(state_code), .p_aux(p_aux), .q_code(q_code)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // Full output pattern of each transition class (R6)
  function automatic logic [13:0] pat_y(input int k);
    case (k)
      1: return 14'h0212; 2: return 14'h000C; 3: return 14'h000D;
      4: return 14'h0600; 5: return 14'h00A0; 6: return 14'h0005;
      7: return 14'h2100; 8: return 14'h0040; 9: return 14'h1020;
      10: return 14'h0800; default: return 14'h0000;
    endcase
  endfunction

  // Reduced code of each pattern (R8)
  function automatic logic [2:0] pat_q(input int k);
    case (k)
      1: return 3'd1; 2: return 3'd2; 3: return 3'd3; 4: return 3'd4;
      5: return 3'd5; 6: return 3'd6; 9: return 3'd7; default: return 3'd0;
    endcase
  endfunction

  // Selection rule for the auxiliary bus (R3)
  function automatic logic [1:0] exp_p(input logic [2:0] s, input logic [7:0] x);
    case (s)
      A1: return {x[1], x[0]};
      A3: return {x[7], x[6]};
      A5: return {x[5], x[3]};
      A7: return {1'b0, x[6]};
      A8: return {x[4], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  // Flat reference table over the original inputs (R4, R5)
  task automatic ref_step(input logic [2:0] s, input logic [7:0] x,
                          output logic [2:0] n, output int k);
    n = s; k = 0;
    case (s)
      A1: if (x[0]) begin n = A2; k = 1; end
      A2: begin n = A3; k = 2; end
      A3: if (x[6] && x[7]) begin n = A4; k = 3; end
          else if (x[6]) begin n = A5; k = 4; end
          else begin n = A6; k = 5; end
      A4: if (x[2]) begin n = A7; k = 6; end else begin n = A8; k = 7; end
      A5: if (x[5]) begin n = A6; k = 8; end else begin n = A1; k = 9; end
      A6: begin n = A7; k = 10; end
      A7: if (x[6]) begin n = A8; k = 2; end
      A8: if (x[4]) begin n = A1; k = 4; end
      default: begin n = s; k = 0; end
    endcase
  endtask

  // Driver: apply inputs, check the bus, push the expected result
  task automatic drive(input logic [7:0] xv);
    exp_t e;
    logic [2:0] nx;
    int k;
    x_in = xv;
    #1;
    chk("R3 p_aux", {14'd0, p_aux}, {14'd0, exp_p(rs, xv)});
    ref_step(rs, xv, nx, k);
    e.st = nx; e.y = pat_y(k); e.q = pat_q(k);
    sb.push_back(e);
    rs = nx;
  endtask

  task automatic step(input logic [7:0] xv);
    @(negedge clk);
    drive(xv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 state", {13'd0, state_code}, {13'd0, A2});
    chk("R1 y_out", {2'd0, y_out}, 16'd0);
    chk("R1 q_code", {13'd0, q_code}, 16'd0);
    sb.delete();
    rs = A2;
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00);
  endtask

  // Monitor: compare each result one edge after it was pushed
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk("R2 R5 state", {13'd0, state_code}, {13'd0, e.st});
        chk("R6 R7 y_out", {2'd0, y_out}, {2'd0, e.y});
        chk("R8 R9 q_code", {13'd0, q_code}, {13'd0, e.q});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2;
    chk("R1 state at start", {13'd0, state_code}, {13'd0, A2});
    chk("R1 y_out at start", {2'd0, y_out}, 16'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h00);            // S2->S3, R10
    step(X7 | X8);           // S3->S4
    step(X3);                // S4->S7 on bypass, R4
    step(8'h00);             // S7 hold, R9
    step(X7);                // S7->S8
    step(8'hEF);             // S8 hold: x5 low, R9
    step(X5);                // S8->S1
    step(8'hFE);             // S1 hold: x1 low, R9
    step(X1);                // S1->S2
    step(8'hFF);             // S2 ignores inputs, R10
    step(X7);                // S3->S5
    step(X4);                // S5->S1 (x4 selected but unused)
    step(X1 | X2);           // S1->S2
    step(8'h00);             // S2->S3
    step(X8);                // S3->S6
    step(8'hFF);             // S6->S7, R10
    step(X7);
    step(X5);
    step(X1);
    step(8'h00);
    step(X7);                // S3->S5
    step(X6);                // S5->S6
    step(8'h00);
    step(X7);
    step(X5);
    step(X1);
    step(8'h00);
    step(X7 | X8);           // S3->S4
    step(8'hFB);             // S4->S8: x3 low, others high, R4
    do_reset();              // mid-run asynchronous reset, R1
    for (int i = 0; i < 400; i++) step(8'($urandom()));
    @(negedge clk);
    rst_n = 1'b0;            // freeze the design before draining
    #1;
    chk("R1 final reset", {13'd0, state_code}, {13'd0, A2});
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule